// File: doc/BRIEF.md
# Asynchronous Single-Bit Static Memory Controller

This block lets a clocked system read and write a one-bit-wide asynchronous static memory with 65,536 locations. The memory has sixteen address lines, a data pin into the memory, a data pin out of it, an active-low select and an active-low write strobe. On the user side, a request is offered with `req_valid`. It carries an address, a write flag and the bit to write, and it is taken on the clock edge where `req_ready` is also high. A read returns its bit on `rd_data`, with a one-clock `rd_valid` strobe.

Each access runs through a small state machine with four states.

- `ST_IDLE`: the memory is deselected and drops into standby.
- `ST_WLOW`: the write strobe is held low for `WE_CYC` cycles.
- `ST_RWAIT`: the memory is selected with the strobe high for `RD_CYC` cycles. The output bit is captured on the last of these cycles.
- `ST_RECOV`: the memory stays selected with the strobe high. Address and write bit stay frozen, which gives the hold time after the write ends.

The transitions are:

- idle→write or idle→read when a request is accepted.
- write→recovery and read→recovery when the cycle timer runs out.
- recovery→write or recovery→read when a follow-on request is accepted, with no deselect in between.
- recovery→idle when no request is waiting.

The write-strobe rising edge always ends a write, with the select still low. The setup and hold limits are therefore met by counting clocks. With a 100 MHz clock and the default counts, an access takes three cycles.

Top module: `asram_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `mem_ce_n`=1, `mem_we_n`=1, `req_ready`=1 and `rd_valid`=0 (the idle state).
- R2: The memory is never strobed while deselected. Whenever `mem_ce_n`=1, `mem_we_n`=1. Select low with strobe low is a write; select low with strobe high is a read.
- R3: A write accepted at clock edge E drives `mem_we_n` low for exactly `WE_CYC` consecutive cycles, starting in the cycle after E. `mem_ce_n` stays low throughout.
- R4: `mem_addr` and `mem_din` take the request's values in the cycle after the accepting edge. They remain unchanged until the cycle after `mem_we_n` (or `mem_ce_n`) is released.
- R5: A read accepted at edge E samples `mem_dout` on edge E+`RD_CYC`. `rd_data` shows the sampled bit during the following cycle, so read-after-write returns the written bit.
- R6: `rd_valid` is high for exactly one clock per read and never for a write.
- R7: `req_ready` is low for the `WE_CYC` or `RD_CYC` cycles after an accept. It is high in idle and in the one recovery cycle that ends each access.
- R8: A request accepted in the recovery cycle keeps `mem_ce_n` low into the next access.
- R9: If no request is offered in the recovery cycle, `mem_ce_n` goes high in the next cycle and stays high until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Location to access |
| req_wdata | input | 1 | Bit to write |
| rd_valid | output | 1 | One-clock strobe marking read data |
| rd_data | output | 1 | Bit returned by a read |
| mem_addr | output | ADDR_W | Address lines to the memory |
| mem_din | output | 1 | Data into the memory |
| mem_dout | input | 1 | Data out of the memory (high impedance when not reading) |
| mem_ce_n | output | 1 | Active-low memory select |
| mem_we_n | output | 1 | Active-low write strobe |

## Verification
The hardest case to reach from the ports is a request accepted in the recovery cycle itself. Here the select must stay low while the address changes, and the frozen address of the previous write must not move before that cycle. The stimulus reaches it by keeping `req_valid` raised and re-offering requests the moment `req_ready` returns. It mixes write-then-read, read-then-write and write-then-write pairs to the same and to different locations. A behavioural model with a memory image and per-cycle expected strobes is compared on every clock. Pauses between bursts exercise the drop to idle.

// File: rtl/asram_pkg.sv
package asram_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WLOW  = 2'd1,
        ST_RWAIT = 2'd2,
        ST_RECOV = 2'd3
    } asram_state_e;
endpackage

// File: rtl/asram_tick.sv
module asram_tick #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int WE_CYC = 2,
    parameter int RD_CYC = 2,
    parameter int CNT_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_zero,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             ce_n,
    output logic             we_n
);
    localparam logic [CNT_W-1:0] WE_LD = CNT_W'(WE_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);

    asram_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_RECOV: begin
                if (req_valid)
                    state_d = req_write ? ST_WLOW : ST_RWAIT;
                else
                    state_d = ST_IDLE;
            end
            ST_WLOW:  if (tmr_zero) state_d = ST_RECOV;
            ST_RWAIT: if (tmr_zero) state_d = ST_RECOV;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        ce_n      = 1'b0;
        we_n      = 1'b1;
        capture   = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin req_ready = 1'b1; ce_n = 1'b1; end
            ST_WLOW:  we_n = 1'b0;
            ST_RWAIT: capture = tmr_zero;
            ST_RECOV: req_ready = 1'b1;
            default:  ce_n = 1'b1;
        endcase
        accept   = req_ready && req_valid;
        tmr_load = accept;
        tmr_val  = req_write ? WE_LD : RD_LD;
    end

    // R7: a busy controller always has the memory selected
    p_busy_selected_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> !ce_n);
    // R3: the strobe only falls in the cycle after an accepted request
    p_we_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> $past(accept));
    // R3: the strobe is released once the timer runs out
    p_we_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WLOW && tmr_zero) |=> we_n);
    // R3: the write ends on the strobe edge with the select still low
    p_we_rise_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> !ce_n);
endmodule

// File: rtl/asram_hold.sv
module asram_hold #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wdata,
    input  logic              capture,
    input  logic              mem_dout,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_din,
    output logic              rd_valid,
    output logic              rd_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_din  <= 1'b0;
        end else if (accept) begin
            mem_addr <= req_addr;
            mem_din  <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture)
                rd_data <= mem_dout;
        end
    end

    // R4: the address and write bit only move after an accept
    p_addr_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(mem_addr) && $stable(mem_din)));
    // R6: the read strobe lasts one clock
    p_rdv_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WE_CYC = 2,
    parameter int RD_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wdata,
    output logic              rd_valid,
    output logic              rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_din,
    input  logic              mem_dout,
    output logic              mem_ce_n,
    output logic              mem_we_n
);
    localparam int MAX_CYC = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
    localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    logic             accept;
    logic             capture;
    logic             tmr_load;
    logic             tmr_zero;
    logic [CNT_W-1:0] tmr_val;

    asram_seq #(.WE_CYC(WE_CYC), .RD_CYC(RD_CYC), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .tmr_zero  (tmr_zero),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .ce_n      (mem_ce_n),
        .we_n      (mem_we_n)
    );

    asram_tick #(.CNT_W(CNT_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    asram_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .mem_dout  (mem_dout),
        .mem_addr  (mem_addr),
        .mem_din   (mem_din),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    // R2: no write strobe while deselected
    p_no_strobe_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> mem_we_n);
    // R4: address and data are held through the strobe release cycle
    p_hold_at_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_din)));
    // R8: a request taken while selected keeps the memory selected
    p_b2b_selected_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && req_ready && req_valid) |=> !mem_ce_n);
    // R9: with nothing to do the memory is deselected
    p_idle_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> mem_ce_n);
endmodule

// File: tb/tb_asram_ctrl.sv
module tb_asram_ctrl;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 16;
    localparam int WE_CYC = 2;
    localparam int RD_CYC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_wdata = 1'b0;
    logic req_ready, rd_valid, rd_data, mem_din, mem_ce_n, mem_we_n;
    logic [ADDR_W-1:0] mem_addr;
    logic mem_dout;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit mon_on = 1'b0;

    // reference state
    bit ref_mem [int];
    int busy_until = -10;
    int w_lo = -10, w_hi = -10;
    int due_q[$];
    bit val_q[$];

    // memory model
    bit mem_arr [int];
    int mem_ev = 0;

    always #(CLK_P/2) clk = ~clk;

    asram_ctrl #(.ADDR_W(ADDR_W), .WE_CYC(WE_CYC), .RD_CYC(RD_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_din(mem_din), .mem_dout(mem_dout), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n)
    );

    function automatic bit mem_get(int a);
        return mem_arr.exists(a) ? mem_arr[a] : 1'b0;
    endfunction

    function automatic bit ref_get(int a);
        return ref_mem.exists(a) ? ref_mem[a] : 1'b0;
    endfunction

    always @(posedge mem_we_n) begin
        if (mem_ce_n === 1'b0) begin
            mem_arr[int'(mem_addr)] = mem_din;
            mem_ev++;
        end
    end

    always @(mem_ce_n or mem_we_n or mem_addr or mem_ev)
        mem_dout = (mem_ce_n === 1'b0 && mem_we_n === 1'b1) ? mem_get(int'(mem_addr)) : 1'bz;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // per-clock comparison against the reference model
    logic              prev_we_n = 1'b1;
    logic [ADDR_W-1:0] prev_addr = '0;
    logic              prev_din = 1'b0;
    int                we_run = 0;
    always @(negedge clk) begin
        if (mon_on) begin
            bit exp_ready, exp_ce_n, exp_we_n;
            cyc++;
            exp_ready = !(cyc <= busy_until);
            exp_ce_n  = !(cyc <= busy_until + 1);
            exp_we_n  = !(cyc >= w_lo && cyc <= w_hi);
            chk(req_ready == exp_ready, "R7 ready", int'(req_ready), int'(exp_ready));
            chk(mem_ce_n == exp_ce_n, "R8/R9 select", int'(mem_ce_n), int'(exp_ce_n));
            chk(mem_we_n == exp_we_n, "R3 strobe", int'(mem_we_n), int'(exp_we_n));
            if (mem_ce_n)
                chk(mem_we_n == 1'b1, "R2 strobe while deselected", int'(mem_we_n), 1);
            if (!mem_we_n) we_run++;
            if (mem_we_n && !prev_we_n) begin
                chk(we_run == WE_CYC, "R3 pulse width", we_run, WE_CYC);
                we_run = 0;
            end
            if (!prev_we_n) begin
                chk(mem_addr == prev_addr, "R4 address held", int'(mem_addr), int'(prev_addr));
                chk(mem_din == prev_din, "R4 data held", int'(mem_din), int'(prev_din));
            end
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                chk(rd_valid == 1'b1, "R5 read strobe", int'(rd_valid), 1);
                chk(rd_data === val_q[0], "R5 read data", int'(rd_data), int'(val_q[0]));
                void'(due_q.pop_front());
                void'(val_q.pop_front());
            end else begin
                chk(rd_valid == 1'b0, "R6 no stray strobe", int'(rd_valid), 0);
            end
            prev_we_n = mem_we_n;
            prev_addr = mem_addr;
            prev_din  = mem_din;
        end
    end

    task automatic issue(input bit wr, input int a, input bit d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = ADDR_W'(a);
        req_wdata = d;
        @(posedge clk);
        if (wr) begin
            busy_until = cyc + WE_CYC;
            w_lo = cyc + 1;
            w_hi = cyc + WE_CYC;
            ref_mem[a] = d;
        end else begin
            busy_until = cyc + RD_CYC;
            due_q.push_back(cyc + RD_CYC + 1);
            val_q.push_back(ref_get(a));
        end
        #1 req_valid = 1'b0;
    endtask

    task automatic pause(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(mem_ce_n == 1'b1, "R1 select in reset", int'(mem_ce_n), 1);
        chk(mem_we_n == 1'b1, "R1 strobe in reset", int'(mem_we_n), 1);
        chk(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
        chk(rd_valid == 1'b0, "R1 read strobe in reset", int'(rd_valid), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        chk(mem_ce_n == 1'b1, "R1 select after reset", int'(mem_ce_n), 1);

        // isolated accesses, boundary addresses, unwritten read (R3, R5, R9)
        issue(1'b0, 16'h1234, 1'b0);
        pause(4);
        issue(1'b1, 0, 1'b1);
        pause(3);
        issue(1'b1, 16'hFFFF, 1'b1);
        pause(3);
        issue(1'b0, 0, 1'b0);
        pause(3);
        issue(1'b0, 16'hFFFF, 1'b0);
        pause(5);
        chk(mem_ce_n == 1'b1, "R9 deselect after gap", int'(mem_ce_n), 1);

        // back-to-back chains (R4, R8): write then read same address
        issue(1'b1, 16'h00A5, 1'b1);
        issue(1'b0, 16'h00A5, 1'b0);
        issue(1'b1, 16'h00A5, 1'b0);
        issue(1'b0, 16'h00A5, 1'b0);
        issue(1'b1, 16'h5A00, 1'b1);
        issue(1'b1, 16'h5A01, 1'b0);
        issue(1'b0, 16'h5A00, 1'b0);
        issue(1'b0, 16'h5A01, 1'b0);
        pause(3);

        // walking-one addresses, data alternating
        for (int i = 0; i < ADDR_W; i++) issue(1'b1, 1 << i, i[0]);
        for (int i = 0; i < ADDR_W; i++) issue(1'b0, 1 << i, 1'b0);
        pause(2);

        // pseudo-random mix with occasional gaps
        begin
            int lfsr = 32'h1ACE;
            for (int k = 0; k < 300; k++) begin
                lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
                issue(lfsr[3], lfsr & 16'h003F, lfsr[7]);
                if (lfsr[12:10] == 3'd0) pause(2);
            end
        end
        pause(6);
        chk(due_q.size() == 0, "R5 all reads returned", due_q.size(), 0);
        chk(mem_ce_n == 1'b1, "R9 final idle", int'(mem_ce_n), 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule